// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block is the processor-side engine that runs one single-master bus transfer over a time-multiplexed address/data bus. A transfer request carries the space (memory or I/O), the direction, the size (byte or word), a 20-bit address, 16-bit write data, the segment code and the interrupt-enable state. The engine then walks the bus through a fixed sequence of clocks. In the first clock it drives the address and pulses the latch strobe. Next come the data clocks, which carry the read or write strobe and the data-buffer enable. A closing clock deasserts every strobe. A slow target can add wait clocks by pulling the ready input low. Another master can take over the bus by raising the hold request. The engine then finishes its current cycle, floats its outputs and acknowledges.

A parameter selects the width of the external data path, either 16 bits or 8 bits. On the 8-bit path only the low byte lane carries data, and the high byte lane keeps the address. A word transfer on that path runs as two back-to-back byte cycles. The low byte goes first.

Tri-state pins are modelled as a value output plus output-enable signals. The AD lanes have one enable per byte. A single enable covers the upper address/status lines and all control outputs.

Top module: `mux_bus_engine`

## Requirements
- R1: After a synchronous reset, the engine is idle with the following outputs: ale=0, rd_n=1, wr_n=1, den_n=1, dtr=0, hlda=0, ad_oe=00 and ctl_oe=1.
- R2: The first clock of a cycle (T1) drives the following:
  - ale=1, with rd_n, wr_n and den_n all high;
  - ad_o = address[15:0] with ad_oe=11, and a_hi = address[19:16];
  - io_sel=1 for I/O space and 0 for memory;
  - bhe_n=0 on the 16-bit path for a word or an odd-address byte, and bhe_n=1 for an even-address byte.
- R3: From the second clock to the end of the cycle, a_hi carries status instead of address. Bit 3 is 0. Bit 2 is the interrupt-enable input. Bits 1:0 are the segment code, where 00 is extra, 01 is stack, 10 is code or none, and 11 is data.
- R4: A read behaves as follows:
  - rd_n and den_n are low from the second clock through the last wait clock, and the data lanes are undriven.
  - AD is captured at the end of the last data clock. On the 16-bit path, a word returns ad_i, and a byte returns ad_i[15:8] for an odd address or ad_i[7:0] for an even one, zero-extended.
  - rdata is valid in the closing clock.
- R5: A write holds wr_n and den_n low through the data clocks, with write data driven and unchanged from the second clock through the closing clock. On the 16-bit path, a word is sent as-is, and a byte is sent as wdata[7:0] on both lanes.
- R6: During the cycle, dtr is 1 for a write and 0 for a read. Outside a cycle, dtr is 0.
- R7: ready is sampled at the end of the third clock and at the end of every wait clock. While it is sampled low, one more wait clock follows with the strobes, status and data unchanged.
- R8: Hold handover works as follows:
  - When hold is high in the idle state, the next clock has hlda=1, ctl_oe=0 and ad_oe=00, and a pending request is not accepted.
  - When hold rises during a cycle, the cycle runs to its closing clock before hlda rises.
  - When hold falls, hlda drops on the next clock.
- R9: On the 8-bit path, the following apply:
  - ad_o[15:8] carries the address bits 15:8 and is driven (ad_oe[1]=1) in every clock of the cycle, including read data clocks.
  - Data moves on ad_o[7:0] and ad_i[7:0] only.
  - bhe_n stays 1.
- R10: On the 8-bit path, a word runs as two cycles with no gap between them:
  - The first cycle transfers the low byte at the given address.
  - The second cycle starts its T1 right after the first closing clock and transfers the high byte at address+1, wrapping at 20 bits.
  - done is raised only in the second closing clock.
- R11: The request and completion handshake works as follows:
  - req_ack is high only in the idle state while req_valid is high and hold is low.
  - done is a one-clock pulse in the closing clock of the last byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ack | output | 1 | Request taken this clock |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| req_seg | input | 2 | Segment code shown in status |
| req_ie | input | 1 | Interrupt-enable state shown in status |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 16 | Read result |
| ready | input | 1 | Target ready, low adds wait clocks |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted, outputs floated |
| ad_i | input | 16 | Value seen on the AD lanes |
| ad_o | output | 16 | Value driven on the AD lanes |
| ad_oe | output | 2 | Output enable per AD byte lane |
| a_hi | output | 4 | Upper address, then status |
| ctl_oe | output | 1 | Output enable for a_hi and control lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dtr | output | 1 | Data direction, 1 = outbound |
| io_sel | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| bhe_n | output | 1 | High byte enable, active low |

## Verification
The assertions assume the reset is held for several clocks before the first request. They also assume that word transfers on the 16-bit path use even addresses, and that request fields stay constant while req_valid is high. The stimulus meets these conditions:
- It raises req_valid only while the engine is idle and drops it right after T1, and it drives only even word addresses to the wide instance.
- It changes ready only between clock edges, with ready low for an exact number of samples per transfer.
- It raises hold either while the engine is idle or in the second clock of a cycle, so the finish-then-grant path is exercised from both directions.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = DATA_W / 2;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int SEG_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_st_e;

    typedef struct packed {
        logic              io;
        logic              write;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [SEG_W-1:0]  seg;
        logic              ie;
    } xfer_t;

    function automatic logic [HI_W-1:0] status_nibble(input logic ie, input logic [SEG_W-1:0] seg);
        return {1'b0, ie, seg};
    endfunction

    function automatic logic is_data_clk(input bus_st_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

    function automatic logic is_in_cycle(input bus_st_e s);
        return (s == ST_T1) || is_data_clk(s) || (s == ST_T4);
    endfunction
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    more,
    input  logic    ready,
    input  logic    hold,
    output bus_st_e st,
    output logic    ack,
    output logic    capture,
    output logic    advance,
    output logic    done
);
    bus_st_e st_q, st_d;
    logic    resume_q, resume_d;

    assign st      = st_q;
    assign ack     = (st_q == ST_IDLE) && req_valid && !hold;
    assign capture = ((st_q == ST_T3) || (st_q == ST_TW)) && ready;
    assign advance = (st_q == ST_T4) && more;
    assign done    = (st_q == ST_T4) && !more;

    always_comb begin
        st_d     = st_q;
        resume_d = resume_q;
        case (st_q)
            ST_IDLE: begin
                if (hold)           st_d = ST_HOLD;
                else if (req_valid) st_d = ST_T1;
            end
            ST_T1: st_d = ST_T2;
            ST_T2: st_d = ST_T3;
            ST_T3, ST_TW: st_d = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                if (hold) begin
                    st_d     = ST_HOLD;
                    resume_d = more;
                end else if (more) begin
                    st_d = ST_T1;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold) begin
                    st_d     = resume_q ? ST_T1 : ST_IDLE;
                    resume_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            resume_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            resume_q <= resume_d;
        end
    end

    // R7: a low ready sample in a data clock adds one wait clock
    a_r7_wait_added: assert property (@(posedge clk) disable iff (rst)
        (((st_q == ST_T3) || (st_q == ST_TW)) && !ready) |=> (st_q == ST_TW));

    // R8: the bus is only surrendered from idle or after a closing clock
    a_r8_grant_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_HOLD) |-> $past((st_q == ST_IDLE) || (st_q == ST_T4)));

    // R11: completion is a single-clock pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/mbus_split.sv
module mbus_split
    import mbus_pkg::*;
#(
    parameter bit BUS16 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  xfer_t             req,
    input  logic              advance,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_i,
    output logic              more,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] lane_out,
    output logic              bhe_n,
    output xfer_t             xfer,
    output logic [DATA_W-1:0] rdata
);
    xfer_t             xfer_q;
    logic [DATA_W-1:0] rdata_q;

    assign xfer  = xfer_q;
    assign rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst)      xfer_q <= '0;
        else if (ack) xfer_q <= req;
    end

    generate
        if (BUS16) begin : g_wide
            assign more     = 1'b0;
            assign cur_addr = xfer_q.addr;
            assign lane_out = xfer_q.word ? xfer_q.wdata
                                          : {2{xfer_q.wdata[LANE_W-1:0]}};
            assign bhe_n    = xfer_q.word ? 1'b0 : ~xfer_q.addr[0];

            always_ff @(posedge clk) begin
                if (rst) begin
                    rdata_q <= '0;
                end else if (capture) begin
                    if (xfer_q.word)        rdata_q <= ad_i;
                    else if (xfer_q.addr[0]) rdata_q <= {{LANE_W{1'b0}}, ad_i[DATA_W-1:LANE_W]};
                    else                     rdata_q <= {{LANE_W{1'b0}}, ad_i[LANE_W-1:0]};
                end
            end
        end else begin : g_narrow
            logic beat_q;

            assign more     = xfer_q.word && !beat_q;
            assign cur_addr = xfer_q.addr + ADDR_W'(beat_q);
            assign lane_out = {cur_addr[DATA_W-1:LANE_W],
                               beat_q ? xfer_q.wdata[DATA_W-1:LANE_W] : xfer_q.wdata[LANE_W-1:0]};
            assign bhe_n    = 1'b1;

            always_ff @(posedge clk) begin
                if (rst) begin
                    beat_q <= 1'b0;
                end else if (ack) begin
                    beat_q <= 1'b0;
                end else if (advance) begin
                    beat_q <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    rdata_q <= '0;
                end else if (capture) begin
                    if (!beat_q) rdata_q <= {{LANE_W{1'b0}}, ad_i[LANE_W-1:0]};
                    else         rdata_q[DATA_W-1:LANE_W] <= ad_i[LANE_W-1:0];
                end
            end

            // R10: the second byte cycle addresses the next byte
            a_r10_next_byte_addr: assert property (@(posedge clk) disable iff (rst)
                advance |=> (cur_addr == ($past(cur_addr) + ADDR_W'(1))));
        end
    endgenerate
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
#(
    parameter bit BUS16 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_st_e           st,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] lane_out,
    input  logic              bhe_in,
    input  xfer_t             xfer,
    output logic [DATA_W-1:0] ad_o,
    output logic [1:0]        ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              ctl_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dtr,
    output logic              io_sel,
    output logic              bhe_n,
    output logic              hlda
);
    logic cyc, dclk, after_addr, drive_lo;

    assign cyc        = is_in_cycle(st);
    assign dclk       = is_data_clk(st);
    assign after_addr = dclk || (st == ST_T4);
    assign drive_lo   = (st == ST_T1) || (after_addr && xfer.write);

    assign ale    = (st == ST_T1);
    assign rd_n   = !(dclk && !xfer.write);
    assign wr_n   = !(dclk && xfer.write);
    assign den_n  = !dclk;
    assign dtr    = cyc && xfer.write;
    assign io_sel = cyc && xfer.io;
    assign bhe_n  = cyc ? bhe_in : 1'b1;
    assign hlda   = (st == ST_HOLD);
    assign ctl_oe = !hlda;

    always_comb begin
        if (st == ST_T1)     a_hi = cur_addr[ADDR_W-1:DATA_W];
        else if (after_addr) a_hi = status_nibble(xfer.ie, xfer.seg);
        else                 a_hi = '0;
    end

    always_comb begin
        if (st == ST_T1)     ad_o = cur_addr[DATA_W-1:0];
        else if (after_addr) ad_o = lane_out;
        else                 ad_o = '0;
    end

    generate
        if (BUS16) begin : g_oe_wide
            assign ad_oe = {drive_lo, drive_lo};
        end else begin : g_oe_narrow
            assign ad_oe = {cyc, drive_lo};
        end
    endgenerate

    // R4, R5: read and write strobes never overlap
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R5: write data held steady while the write strobe stays low
    a_r5_wdata_steady: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> ($stable(ad_o) && (ad_oe == 2'b11)));

    // R3: top status bit is low in every data clock
    a_r3_s6_low: assert property (@(posedge clk) disable iff (rst)
        !den_n |-> (a_hi[HI_W-1] == 1'b0));

    // R8: granted bus means every output floats
    a_r8_float: assert property (@(posedge clk) disable iff (rst)
        hlda |-> ((ad_oe == 2'b00) && !ctl_oe));

    // R2: address strobe only while no data strobe is active
    a_r2_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n && den_n));
endmodule

// File: rtl/mux_bus_engine.sv
module mux_bus_engine
    import mbus_pkg::*;
#(
    parameter bit BUS16 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic [1:0]        ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              ctl_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dtr,
    output logic              io_sel,
    output logic              bhe_n
);
    bus_st_e           st;
    logic              ack, capture, advance, more, bhe_int;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] lane_out;
    xfer_t             req, xfer;

    assign req_ack = ack;

    always_comb begin
        req.io    = req_io;
        req.write = req_write;
        req.word  = req_word;
        req.addr  = req_addr;
        req.wdata = req_wdata;
        req.seg   = req_seg;
        req.ie    = req_ie;
    end

    mbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .more      (more),
        .ready     (ready),
        .hold      (hold),
        .st        (st),
        .ack       (ack),
        .capture   (capture),
        .advance   (advance),
        .done      (done)
    );

    mbus_split #(.BUS16(BUS16)) u_split (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .req      (req),
        .advance  (advance),
        .capture  (capture),
        .ad_i     (ad_i),
        .more     (more),
        .cur_addr (cur_addr),
        .lane_out (lane_out),
        .bhe_n    (bhe_int),
        .xfer     (xfer),
        .rdata    (rdata)
    );

    mbus_pins #(.BUS16(BUS16)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .cur_addr (cur_addr),
        .lane_out (lane_out),
        .bhe_in   (bhe_int),
        .xfer     (xfer),
        .ad_o     (ad_o),
        .ad_oe    (ad_oe),
        .a_hi     (a_hi),
        .ctl_oe   (ctl_oe),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .den_n    (den_n),
        .dtr      (dtr),
        .io_sel   (io_sel),
        .bhe_n    (bhe_n),
        .hlda     (hlda)
    );
endmodule

// File: tb/test_mux_bus_engine.sv
`timescale 1ns/1ps
module test_mux_bus_engine;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, wv, nv, req_io, req_write, req_word, req_ie, ready, hold;
    logic [19:0] req_addr;
    logic [15:0] req_wdata, ad_i;
    logic [1:0]  req_seg;

    logic        w_ack, w_done, w_hlda, w_ctl_oe, w_ale, w_rd_n, w_wr_n, w_den_n, w_dtr, w_io, w_bhe;
    logic [15:0] w_rdata, w_ad;
    logic [1:0]  w_oe;
    logic [3:0]  w_ahi;
    logic        n_ack, n_done, n_hlda, n_ctl_oe, n_ale, n_rd_n, n_wr_n, n_den_n, n_dtr, n_io, n_bhe;
    logic [15:0] n_rdata, n_ad;
    logic [1:0]  n_oe;
    logic [3:0]  n_ahi;

    mux_bus_engine #(.BUS16(1'b1)) i_mux_bus_engine (
        .clk(clk), .rst(rst), .req_valid(wv), .req_ack(w_ack), .req_io(req_io),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie), .done(w_done),
        .rdata(w_rdata), .ready(ready), .hold(hold), .hlda(w_hlda), .ad_i(ad_i),
        .ad_o(w_ad), .ad_oe(w_oe), .a_hi(w_ahi), .ctl_oe(w_ctl_oe), .ale(w_ale),
        .rd_n(w_rd_n), .wr_n(w_wr_n), .den_n(w_den_n), .dtr(w_dtr), .io_sel(w_io),
        .bhe_n(w_bhe));

    mux_bus_engine #(.BUS16(1'b0)) i_mux_bus_engine_narrow (
        .clk(clk), .rst(rst), .req_valid(nv), .req_ack(n_ack), .req_io(req_io),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie), .done(n_done),
        .rdata(n_rdata), .ready(ready), .hold(hold), .hlda(n_hlda), .ad_i(ad_i),
        .ad_o(n_ad), .ad_oe(n_oe), .a_hi(n_ahi), .ctl_oe(n_ctl_oe), .ale(n_ale),
        .rd_n(n_rd_n), .wr_n(n_wr_n), .den_n(n_den_n), .dtr(n_dtr), .io_sel(n_io),
        .bhe_n(n_bhe));

    // observed port set, selected per test
    logic        sel;
    logic        o_ack, o_done, o_hlda, o_ctl_oe, o_dtr, o_io, o_bhe;
    logic [3:0]  o_strb, o_ahi;
    logic [15:0] o_rdata, o_ad;
    logic [1:0]  o_oe;
    always_comb begin
        o_ack    = sel ? n_ack    : w_ack;
        o_done   = sel ? n_done   : w_done;
        o_hlda   = sel ? n_hlda   : w_hlda;
        o_ctl_oe = sel ? n_ctl_oe : w_ctl_oe;
        o_dtr    = sel ? n_dtr    : w_dtr;
        o_io     = sel ? n_io     : w_io;
        o_bhe    = sel ? n_bhe    : w_bhe;
        o_strb   = sel ? {n_ale, n_rd_n, n_wr_n, n_den_n} : {w_ale, w_rd_n, w_wr_n, w_den_n};
        o_ahi    = sel ? n_ahi    : w_ahi;
        o_rdata  = sel ? n_rdata  : w_rdata;
        o_ad     = sel ? n_ad     : w_ad;
        o_oe     = sel ? n_oe     : w_oe;
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "idle strobes {ale,rd_n,wr_n,den_n}", {28'd0, o_strb}, 32'h7);
        chk(tag, "idle ad_oe", {30'd0, o_oe}, 32'h0);
        chk(tag, "idle hlda/ctl_oe", {30'd0, o_hlda, o_ctl_oe}, 32'h1);
        chk(tag, "idle dtr", {31'd0, o_dtr}, 32'h0);
    endtask

    task automatic run_xfer(input bit nar, input bit io, input bit wr, input bit word,
                            input logic [19:0] addr, input logic [15:0] wd, input logic [1:0] seg,
                            input bit ie, input int nwait, input logic [15:0] rv, input bit hold_mid);
        int          nb;
        logic [19:0] ba;
        logic [15:0] dexp, rexp;
        logic        bexp;
        string       dtag;
        sel = nar;
        @(negedge clk);
        req_io = io; req_write = wr; req_word = word; req_addr = addr;
        req_wdata = wd; req_seg = seg; req_ie = ie; ready = 1'b1;
        if (nar) nv = 1'b1; else wv = 1'b1;
        #1;
        chk("R11", "req_ack in idle", {31'd0, o_ack}, 32'h1);
        nb = (nar && word) ? 2 : 1;
        for (int b = 0; b < nb; b++) begin
            ba = addr + 20'(b);
            if (nar) dexp = {ba[15:8], (b == 1) ? wd[15:8] : wd[7:0]};
            else     dexp = word ? wd : {wd[7:0], wd[7:0]};
            bexp = nar ? 1'b1 : (word ? 1'b0 : ~addr[0]);
            dtag = nar ? (word ? "R10" : "R9") : (wr ? "R5" : "R4");
            // T1
            @(negedge clk);
            ad_i = nar ? {8'hA5, (b == 1) ? rv[15:8] : rv[7:0]} : rv;
            #1;
            chk("R2", "T1 strobes", {28'd0, o_strb}, 32'hF);
            chk(nar ? "R10" : "R2", "T1 address lanes", {16'd0, o_ad}, {16'd0, ba[15:0]});
            chk("R2", "T1 ad_oe", {30'd0, o_oe}, 32'h3);
            chk("R2", "T1 upper address", {28'd0, o_ahi}, {28'd0, ba[19:16]});
            chk("R2", "T1 io_sel", {31'd0, o_io}, {31'd0, io});
            chk(nar ? "R9" : "R2", "T1 bhe_n", {31'd0, o_bhe}, {31'd0, bexp});
            chk("R6", "T1 dtr", {31'd0, o_dtr}, {31'd0, wr});
            if (b == 0) begin
                chk("R11", "req_ack while busy", {31'd0, o_ack}, 32'h0);
                wv = 1'b0; nv = 1'b0;
            end
            // data clocks: T2, T3, waits
            for (int k = 0; k < 2 + nwait; k++) begin
                @(negedge clk);
                if (k >= 1) ready = ((k - 1) == nwait);
                if (hold_mid && k == 0 && b == nb - 1) hold = 1'b1;
                #1;
                chk((k >= 2) ? "R7" : (wr ? "R5" : "R4"), "data-clock strobes",
                    {28'd0, o_strb}, {28'd0, 1'b0, wr, ~wr, 1'b0});
                chk("R3", "status lines", {28'd0, o_ahi}, {28'd0, 1'b0, ie, seg});
                chk("R6", "data-clock dtr", {31'd0, o_dtr}, {31'd0, wr});
                if (wr) begin
                    chk(dtag, "write data lanes", {16'd0, o_ad}, {16'd0, dexp});
                    chk(dtag, "write ad_oe", {30'd0, o_oe}, 32'h3);
                end else begin
                    chk(nar ? "R9" : "R4", "read ad_oe", {30'd0, o_oe}, nar ? 32'h2 : 32'h0);
                    if (nar) chk("R9", "read high lane address", {24'd0, o_ad[15:8]}, {24'd0, ba[15:8]});
                end
            end
            // T4
            @(negedge clk);
            ready = 1'b1;
            #1;
            chk("R4", "T4 strobes", {28'd0, o_strb}, 32'h7);
            chk((nb == 2) ? "R10" : "R11", "T4 done", {31'd0, o_done}, {31'd0, (b == nb - 1)});
            chk("R6", "T4 dtr", {31'd0, o_dtr}, {31'd0, wr});
            if (wr) chk(dtag, "T4 write data held", {16'd0, o_ad}, {16'd0, dexp});
            if (!wr && b == nb - 1) begin
                if (nar)       rexp = word ? rv : {8'h00, rv[7:0]};
                else if (word) rexp = rv;
                else           rexp = {8'h00, addr[0] ? rv[15:8] : rv[7:0]};
                chk(nar ? "R10" : "R4", "read result", {16'd0, o_rdata}, {16'd0, rexp});
            end
        end
        @(negedge clk);
        #1;
        if (hold_mid) begin
            chk("R8", "hlda after finished cycle", {31'd0, o_hlda}, 32'h1);
            chk("R8", "floated outputs", {29'd0, o_oe, o_ctl_oe}, 32'h0);
            hold = 1'b0;
            @(negedge clk);
            #1;
            chk_idle("R8");
        end else begin
            chk("R11", "done back low", {31'd0, o_done}, 32'h0);
            chk_idle("R11");
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; wv = 1'b0; nv = 1'b0; req_io = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_addr = '0; req_wdata = '0; req_seg = '0; req_ie = 1'b0; ready = 1'b1;
        hold = 1'b0; ad_i = '0; sel = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        sel = 1'b0; #1; chk_idle("R1");
        sel = 1'b1; #1; chk_idle("R1");

        // wide path
        run_xfer(1'b0, 1'b0, 1'b0, 1'b1, 20'hA1234, 16'h0000, 2'b10, 1'b1, 0, 16'hBEEF, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b1, 1'b1, 20'h50F00, 16'h1357, 2'b01, 1'b0, 2, 16'h0000, 1'b0);
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 20'hFFFF1, 16'h0000, 2'b11, 1'b1, 1, 16'hC33C, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b1, 1'b0, 20'h00010, 16'h77AA, 2'b00, 1'b0, 0, 16'h0000, 1'b0);
        run_xfer(1'b0, 1'b1, 1'b1, 1'b0, 20'h2468B, 16'h0F5E, 2'b10, 1'b1, 3, 16'h0000, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 20'h13572, 16'h0000, 2'b01, 1'b0, 0, 16'h6D92, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b0, 1'b1, 20'h0ABCE, 16'h0000, 2'b11, 1'b0, 1, 16'h8421, 1'b1);

        // hold taken from idle; a pending request must not be accepted
        sel = 1'b0;
        @(negedge clk);
        hold = 1'b1; wv = 1'b1; req_addr = 20'h11110;
        #1;
        chk("R8", "req_ack blocked by hold", {31'd0, o_ack}, 32'h0);
        chk("R8", "hlda not yet", {31'd0, o_hlda}, 32'h0);
        @(negedge clk);
        wv = 1'b0;
        #1;
        chk("R8", "hlda from idle", {31'd0, o_hlda}, 32'h1);
        chk("R8", "float from idle", {29'd0, o_oe, o_ctl_oe}, 32'h0);
        chk("R8", "no address strobe in hold", {28'd0, o_strb}, 32'h7);
        repeat (2) @(negedge clk);
        hold = 1'b0;
        @(negedge clk);
        #1;
        chk_idle("R8");

        // narrow path
        run_xfer(1'b1, 1'b0, 1'b0, 1'b1, 20'h300FF, 16'h0000, 2'b10, 1'b1, 1, 16'h9A5B, 1'b0);
        run_xfer(1'b1, 1'b0, 1'b1, 1'b1, 20'hFFFFF, 16'h4321, 2'b01, 1'b0, 0, 16'h0000, 1'b0);
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 20'h7C0D3, 16'h0000, 2'b00, 1'b1, 2, 16'h3E71, 1'b0);
        run_xfer(1'b1, 1'b1, 1'b1, 1'b0, 20'h0004E, 16'hD2B6, 2'b11, 1'b0, 0, 16'h0000, 1'b0);

        summary();
        $finish;
    end
endmodule